// File: doc/BRIEF.md
# Four-Channel Command-Strobe Interval Timer

This block holds a bank of identical up-counting timer channels behind a small register port. Each channel counts pulses on its own tick-enable input, so every channel can run at a different divided rate taken from elsewhere in the chip. A channel compares its count against a programmable terminal value. Each time the count meets that value it flags a pending event. In continuous operation it starts over from zero. In one-shot operation it stops and drops back to idle. Each channel drives its own level interrupt, gated by a per-channel interrupt enable.

Software controls a channel through separate command addresses for reset, enable and disable. A write to any of these acts as a strobe, and its data is ignored. Software sets the mode, terminal value and interrupt enable through ordinary register writes. It reads a packed status word and the live count, and clears a pending event by writing an acknowledge word. One shared register drives a clock-request output. Register reads are combinational from the address, and writes take effect on the next clock edge.

Top module: `cmd_timer_bank`

## Requirements
- R1: Channel n occupies byte addresses n*0x40 to n*0x40+0x3F. Its registers sit at these offsets inside that window: reset command 0x00, enable command 0x04, disable command 0x08, mode 0x0C, status 0x10, count 0x14, terminal 0x18, interrupt enable 0x1C and acknowledge 0x20. A write to any command address performs the command whatever the data is.
- R2: After an enable command, the channel's status bit 4 reads 1 and its state field (status bits 3:0) reads 2, meaning active. After a disable command, bit 4 reads 0 and the state field reads 1, meaning idle.
- R3: While the channel is enabled, each clock cycle with its tick-enable high increments the count by one. While the channel is disabled, tick pulses leave the count unchanged.
- R4: In continuous mode (mode bit 0 = 0), a tick that arrives while the count equals the terminal value sets pending and returns the count to 0. With the terminal value at all ones, the channel is therefore a free-running counter that wraps.
- R5: In one-shot mode (mode bit 0 = 1), a tick that arrives while the count equals the terminal value does three things. It sets pending, it clears the enable so the state field reads 1, and it leaves the count at the terminal value. Later ticks do not change the count.
- R6: A reset command sets the count to 0, clears pending and leaves the channel disabled and idle. The terminal value, mode and interrupt enable keep their values.
- R7: The status word reads pending in bit 7, interrupt enable in bit 6, one-shot mode in bit 5, enabled in bit 4 and the state code in bits 3:0. All higher bits read 0.
- R8: A channel's irq output is high exactly when pending is set and interrupt-enable bit 0 is 1. Pending stays visible in the status word while the interrupt is disabled.
- R9: A write to the acknowledge address with data bit 7 set clears pending. With bit 7 clear, the write has no effect. If a terminal event occurs in the same cycle as the acknowledge write, pending stays set.
- R10: The terminal register reads back the value that was written to it. Command, mode, interrupt-enable, acknowledge and unmapped addresses read as 0.
- R11: The shared register at byte address 0x100 stores bit 0 of a write. It reads back in bit 0 and drives clk_req.
- R12: A write to one channel's window changes no other channel's state.
- R13: After reset, every channel has count 0, terminal value all ones, continuous mode, interrupt disabled, disabled/idle state and no pending event. clk_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | NUM_CH | Per-channel count-enable pulses |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | Per-channel level interrupts |
| clk_req | output | 1 | Clock-request bit of the shared register |

## Verification
The bench builds the block with NUM_CH = 4 and CNT_W = 8. The 8-bit counter lets the all-ones terminal value, and therefore the wrap of a free-running channel, be reached in a few hundred ticks instead of four billion. Four channels let one channel be checked in each mode while the others show that their state is untouched. Short terminal values put the terminal event next to an acknowledge write in the same cycle, and put a one-shot stop next to later ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 9;

    // Per-channel register offsets inside the channel window
    localparam logic [5:0] OFF_RST  = 6'h00;
    localparam logic [5:0] OFF_EN   = 6'h04;
    localparam logic [5:0] OFF_DIS  = 6'h08;
    localparam logic [5:0] OFF_MODE = 6'h0C;
    localparam logic [5:0] OFF_STAT = 6'h10;
    localparam logic [5:0] OFF_CNT  = 6'h14;
    localparam logic [5:0] OFF_TERM = 6'h18;
    localparam logic [5:0] OFF_IE   = 6'h1C;
    localparam logic [5:0] OFF_ACK  = 6'h20;

    localparam logic [ADDR_W-1:0] ADDR_CLKREQ = 9'h100;

    localparam logic [3:0] ST_IDLE   = 4'd1;
    localparam logic [3:0] ST_ACTIVE = 4'd2;

    localparam int ACK_BIT = 7;

    typedef struct packed {
        logic do_rst;
        logic do_en;
        logic do_dis;
        logic wr_mode;
        logic wr_term;
        logic wr_ie;
        logic wr_ack;
    } ch_cmd_t;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    output ch_cmd_t [NUM_CH-1:0]    cmd,
    output logic                    clkreq_wr
);

    logic [5:0] off;
    assign off = bus_addr[5:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = bus_wr && !bus_addr[8] && (bus_addr[7:6] == 2'(i));
        assign cmd[i].do_rst  = sel && (off == OFF_RST);
        assign cmd[i].do_en   = sel && (off == OFF_EN);
        assign cmd[i].do_dis  = sel && (off == OFF_DIS);
        assign cmd[i].wr_mode = sel && (off == OFF_MODE);
        assign cmd[i].wr_term = sel && (off == OFF_TERM);
        assign cmd[i].wr_ie   = sel && (off == OFF_IE);
        assign cmd[i].wr_ack  = sel && (off == OFF_ACK);
    end

    assign clkreq_wr = bus_wr && (bus_addr == ADDR_CLKREQ);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  ch_cmd_t           cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        status,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  term,
    output logic              irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] term;
        logic             en;
        logic             oneshot;
        logic             ie;
        logic             pend;
    } ch_reg_t;

    localparam ch_reg_t RST_VAL = '{cnt: '0, term: '1, en: 1'b0,
                                    oneshot: 1'b0, ie: 1'b0, pend: 1'b0};

    ch_reg_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = st_q.en && tick && (st_q.cnt == st_q.term);

        if (hit) begin
            st_d.pend = 1'b1;
            if (st_q.oneshot) st_d.en  = 1'b0;
            else              st_d.cnt = '0;
        end else if (st_q.en && tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (cmd.wr_mode) st_d.oneshot = wdata[0];
        if (cmd.wr_term) st_d.term    = wdata[CNT_W-1:0];
        if (cmd.wr_ie)   st_d.ie      = wdata[0];

        // a terminal event in the same cycle wins over the acknowledge
        if (cmd.wr_ack && wdata[ACK_BIT] && !hit) st_d.pend = 1'b0;

        if (cmd.do_dis) st_d.en = 1'b0;
        if (cmd.do_en)  st_d.en = 1'b1;

        if (cmd.do_rst) begin
            st_d.cnt  = '0;
            st_d.pend = 1'b0;
            st_d.en   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign status = {st_q.pend, st_q.ie, st_q.oneshot, st_q.en,
                     st_q.en ? ST_ACTIVE : ST_IDLE};
    assign count  = st_q.cnt;
    assign term   = st_q.term;
    assign irq    = st_q.pend && st_q.ie;

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][7:0]        status,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  count,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  term,
    input  logic                          clkreq,
    output logic [DATA_W-1:0]             rdata
);

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CLKREQ) begin
            rdata[0] = clkreq;
        end else if (!addr[8]) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr[7:6] == 2'(i)) begin
                    case (addr[5:0])
                        OFF_STAT: rdata[7:0]       = status[i];
                        OFF_CNT:  rdata[CNT_W-1:0] = count[i];
                        OFF_TERM: rdata[CNT_W-1:0] = term[i];
                        default:  rdata            = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/cmd_timer_bank.sv
module cmd_timer_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tick_en,
    input  logic              bus_wr,
    input  logic [8:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq,
    output logic              clk_req
);

    ch_cmd_t [NUM_CH-1:0]           cmd;
    logic                           clkreq_wr;
    logic [NUM_CH-1:0][7:0]         ch_status;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_count;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_term;
    logic                           req_d, req_q;

    tmr_decode #(.NUM_CH(NUM_CH)) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .cmd       (cmd),
        .clkreq_wr (clkreq_wr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_en[i]),
            .cmd    (cmd[i]),
            .wdata  (bus_wdata),
            .status (ch_status[i]),
            .count  (ch_count[i]),
            .term   (ch_term[i]),
            .irq    (irq[i])
        );
    end

    always_comb begin
        req_d = req_q;
        if (clkreq_wr) req_d = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign clk_req = req_q;

    tmr_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_rdmux (
        .addr   (bus_addr),
        .status (ch_status),
        .count  (ch_count),
        .term   (ch_term),
        .clkreq (req_q),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CH-1:0]             tick_en,
    input logic                          bus_wr,
    input logic [8:0]                    bus_addr,
    input logic [31:0]                   bus_wdata,
    input logic [NUM_CH-1:0][7:0]        ch_status,
    input logic [NUM_CH-1:0][CNT_W-1:0]  ch_count,
    input logic [NUM_CH-1:0][CNT_W-1:0]  ch_term
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic ch_wr, at_term;
        assign ch_wr   = bus_wr && !bus_addr[8] && (bus_addr[7:6] == 2'(i));
        assign at_term = ch_status[i][4] && tick_en[i] && (ch_count[i] == ch_term[i]);

        AST_RST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 9'(i * 64))
            |=> (ch_count[i] == '0 && !ch_status[i][7] && !ch_status[i][4])); // R6

        AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            (at_term && !ch_status[i][5] && !ch_wr)
            |=> (ch_count[i] == '0 && ch_status[i][7])); // R4

        AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            (at_term && ch_status[i][5] && !ch_wr)
            |=> (!ch_status[i][4] && ch_status[i][7] && ch_count[i] == $past(ch_count[i]))); // R5

        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_status[i][4] && !ch_wr) |=> $stable(ch_count[i])); // R3

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 9'(i * 64 + 32) && bus_wdata[7] && !at_term)
            |=> !ch_status[i][7]); // R9
    end

endmodule

bind cmd_timer_bank timer_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ch_status (ch_status),
    .ch_count  (ch_count),
    .ch_term   (ch_term)
);

// File: tb/test_cmd_timer_bank.sv
`timescale 1ns/1ps
module test_cmd_timer_bank;

    localparam int NUM_CH = 4;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] tick_en = '0;
    logic              bus_wr = 1'b0;
    logic [8:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] irq;
    logic              clk_req;

    always #2.5 clk = ~clk;

    cmd_timer_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_cmd_timer_bank (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .clk_req(clk_req)
    );

    // kind 0: bus_rdata at addr; kind 1: irq vector; kind 2: clk_req
    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] exp;
        int unsigned rq;
    } item_t;

    item_t q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            wait (q.size() != 0);
            #1;
            begin
                item_t it;
                logic [31:0] act;
                it  = q[0];
                act = (it.kind == 2'd0) ? bus_rdata :
                      (it.kind == 2'd1) ? 32'(irq) : 32'(clk_req);
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL R%0d: kind %0d addr 0x%03h actual 0x%08h expected 0x%08h",
                             it.rq, it.kind, bus_addr, act, it.exp);
                end
                void'(q.pop_front());
            end
        end
    end

    task automatic push_and_wait(item_t it);
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic exp_rd(input logic [8:0] a, input logic [31:0] e, input int unsigned rq);
        @(negedge clk);
        bus_addr = a;
        push_and_wait('{kind: 2'd0, exp: e, rq: rq});
    endtask

    task automatic exp_irq(input logic [NUM_CH-1:0] e, input int unsigned rq);
        @(negedge clk);
        push_and_wait('{kind: 2'd1, exp: 32'(e), rq: rq});
    endtask

    task automatic exp_req(input logic e, input int unsigned rq);
        @(negedge clk);
        push_and_wait('{kind: 2'd2, exp: 32'(e), rq: rq});
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic ticks(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en[ch] = 1'b1;
        end
        @(negedge clk);
        tick_en[ch] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        exp_rd(9'h010, 32'h01, 13);
        exp_rd(9'h014, 32'h00, 13);
        exp_rd(9'h018, 32'hFF, 13);
        exp_irq(4'b0000, 13);
        exp_req(1'b0, 13);

        // R10 write-only and unmapped read as zero
        exp_rd(9'h000, 32'h0, 10);
        exp_rd(9'h00C, 32'h0, 10);
        exp_rd(9'h024, 32'h0, 10);
        exp_rd(9'h104, 32'h0, 10);

        // R1 R2 enable command with ignored data
        wr(9'h044, 32'h0000_0000);
        exp_rd(9'h050, 32'h12, 2);
        exp_rd(9'h010, 32'h01, 12);  // R12 channel 0 untouched
        // R3 counting
        ticks(1, 5);
        exp_rd(9'h054, 32'd5, 3);
        ticks(0, 3);
        exp_rd(9'h014, 32'd0, 3);    // R3 disabled channel holds
        wr(9'h048, 32'hDEAD_BEEF);   // R1 disable, data ignored
        exp_rd(9'h050, 32'h01, 2);
        ticks(1, 3);
        exp_rd(9'h054, 32'd5, 3);

        // R4 continuous on channel 2, terminal 3
        wr(9'h098, 32'd3);
        wr(9'h09C, 32'd1);
        wr(9'h084, 32'd0);
        exp_rd(9'h098, 32'd3, 10);
        ticks(2, 3);
        exp_rd(9'h094, 32'd3, 4);
        exp_irq(4'b0000, 8);
        ticks(2, 1);
        exp_rd(9'h094, 32'd0, 4);
        exp_rd(9'h090, 32'hD2, 7);   // R7 pending|ie|en|active
        exp_irq(4'b0100, 8);
        // R9 acknowledge without bit 7 does nothing, with bit 7 clears
        wr(9'h0A0, 32'h7F);
        exp_rd(9'h090, 32'hD2, 9);
        wr(9'h0A0, 32'h80);
        exp_rd(9'h090, 32'h52, 9);
        exp_irq(4'b0000, 9);
        // R8 masking keeps pending visible
        ticks(2, 4);
        wr(9'h09C, 32'd0);
        exp_rd(9'h090, 32'h92, 8);
        exp_irq(4'b0000, 8);
        wr(9'h09C, 32'd1);
        exp_irq(4'b0100, 8);
        wr(9'h0A0, 32'h80);
        // R9 terminal event in the same cycle as acknowledge
        ticks(2, 3);
        exp_rd(9'h094, 32'd3, 9);
        @(negedge clk);
        tick_en[2] = 1'b1; bus_wr = 1'b1; bus_addr = 9'h0A0; bus_wdata = 32'h80;
        @(negedge clk);
        tick_en[2] = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        exp_rd(9'h090, 32'hD2, 9);
        exp_rd(9'h094, 32'd0, 9);
        wr(9'h0A0, 32'h80);

        // R5 one-shot on channel 3, terminal 2
        wr(9'h0CC, 32'd1);
        wr(9'h0D8, 32'd2);
        wr(9'h0DC, 32'd1);
        wr(9'h0C4, 32'd0);
        exp_rd(9'h0D0, 32'h72, 7);
        ticks(3, 3);
        exp_rd(9'h0D4, 32'd2, 5);
        exp_rd(9'h0D0, 32'hE1, 5);
        exp_irq(4'b1000, 5);
        ticks(3, 2);
        exp_rd(9'h0D4, 32'd2, 5);
        // R6 reset command keeps settings
        wr(9'h0C0, 32'h0000_1234);
        exp_rd(9'h0D0, 32'h61, 6);
        exp_rd(9'h0D4, 32'd0, 6);
        exp_rd(9'h0D8, 32'd2, 6);
        exp_irq(4'b0000, 6);

        // R4 free-running wrap at all-ones terminal on channel 0
        wr(9'h004, 32'd0);
        ticks(0, 255);
        exp_rd(9'h014, 32'hFF, 4);
        ticks(0, 1);
        exp_rd(9'h014, 32'h00, 4);
        exp_rd(9'h010, 32'h92, 4);
        exp_irq(4'b0000, 8);
        exp_rd(9'h054, 32'd5, 12);   // R12 channel 1 untouched

        // R11 shared clock-request bit
        wr(9'h100, 32'hFFFF_FFFF);
        exp_rd(9'h100, 32'h1, 11);
        exp_req(1'b1, 11);
        wr(9'h100, 32'h0);
        exp_rd(9'h100, 32'h0, 11);
        exp_req(1'b0, 11);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule